// File: doc/BRIEF.md
# Self-Identification Packet Validator and Decoder

This block sits behind the receive path of a serial-bus PHY interface while the bus is self-identifying. Each node on the bus sends a two-quadlet packet. The second quadlet carries the bitwise complement of the first, so a corrupted packet can be detected. The block collects such a pair and checks it. When the pair is sound, it unpacks the sending node's fields into registered outputs and pulses an accept strobe. When the pair is not sound, it pulses a reject strobe and leaves the previously decoded fields untouched.

The receive logic marks the start of a packet with `q_start` and qualifies every 32-bit quadlet with `q_valid`. Bit 0 is the most significant bit of a quadlet, so bit 0 is `q_data[31]`. Only the contents of one packet are reported, including the flag saying that more packets from the same node follow. Building topology or speed maps belongs to logic downstream.

Top module: `sid_decode`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `pkt_ok` and `pkt_err` are 0 and every decoded field output is 0.
- R2: A sound pair produces a one-cycle `pkt_ok` in the cycle after the second quadlet is taken. From that cycle the fields hold the following values from the first quadlet: `sender_id` = bits 2..7, `link_active` = bit 9, `gap_count` = bits 10..15, `phy_speed` = bits 16..17, `phy_delay` = bits 18..19, `contender` = bit 20, `power_class` = bits 21..23, `port_stat` = bits 24..29 (port 0 in its top two bits), `init_reset` = bit 30 and `more_pkts` = bit 31. Bit 0 is `q_data[31]`, and bit n is `q_data[31-n]`.
- R3: If the second quadlet is not the exact bitwise complement of the first, `pkt_err` pulses for one cycle in the same position and all field outputs keep their previous values.
- R4: If bits 0..1 of the first quadlet are not 2'b01, the pair is rejected with `pkt_err`, and the fields are unchanged.
- R5: If bit 8 of the first quadlet is 1, the pair is rejected with `pkt_err`, and the fields are unchanged.
- R6: `pkt_ok` and `pkt_err` are never high together, and each lasts exactly one cycle per packet.
- R7: Quadlets strobed with no preceding `q_start` (or after a packet has completed) are ignored: no pulse, and no field change.
- R8: A `q_start` that arrives after the first quadlet but before the second discards the held quadlet. The next valid quadlet becomes the new first quadlet.
- R9: A quadlet whose `q_valid` coincides with `q_start` is taken as the first quadlet of the packet.
- R10: Cycles with `q_valid` low between or before the quadlets of a packet do not disturb it, whatever `q_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| q_start | input | 1 | Packet-start marker |
| q_valid | input | 1 | Quadlet strobe |
| q_data | input | 32 | Quadlet, bit 0 = MSB |
| pkt_ok | output | 1 | One-cycle accept pulse |
| pkt_err | output | 1 | One-cycle reject pulse |
| sender_id | output | 6 | Sending node's PHY identifier |
| link_active | output | 1 | Link layer active flag |
| gap_count | output | 6 | Gap count |
| phy_speed | output | 2 | Speed code |
| phy_delay | output | 2 | Delay code |
| contender | output | 1 | Contender flag |
| power_class | output | 3 | Power class |
| port_stat | output | 6 | Port status pairs, port 0 first |
| init_reset | output | 1 | Node initiated the reset |
| more_pkts | output | 1 | More packets follow |

## Verification
The bench builds the block with its defaults: a 32-bit quadlet, three ports and the reserved-bit check enabled. These are the values under which bit 8 and all three port pairs are live, so every rejection cause in R3 to R5 can be reached and every field position in R2 can be observed. Random packets take random field contents, random corruption and random idle gaps. The directed sequences cover restart, start coinciding with data, and strobes outside a packet.

// File: rtl/sid_pkg.sv
package sid_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ARMED = 2'd1,
      SQ_HELD  = 2'd2
   } sq_state_t;

   // number of fixed (non-port) bits in a quadlet
   localparam int FIXED_BITS = 26;
   localparam int PORT_FIELD_W = 2;
endpackage

// File: rtl/sid_seq.sv
module sid_seq
   import sid_pkg::*;
#(
   parameter int QUAD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_start,
   input  logic              q_valid,
   input  logic [QUAD_W-1:0] q_data,
   output logic              cmp_fire,
   output logic [QUAD_W-1:0] held_q
);
   sq_state_t state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         held_q <= '0;
      end else if (q_start) begin
         if (q_valid) begin
            held_q <= q_data;
            state  <= SQ_HELD;
         end else begin
            state  <= SQ_ARMED;
         end
      end else if (q_valid) begin
         case (state)
            SQ_ARMED: begin
               held_q <= q_data;
               state  <= SQ_HELD;
            end
            SQ_HELD:  state <= SQ_IDLE;
            default:  state <= SQ_IDLE;
         endcase
      end
   end

   assign cmp_fire = q_valid && !q_start && (state == SQ_HELD);
endmodule

// File: rtl/sid_check.sv
module sid_check #(
   parameter int QUAD_W     = 32,
   parameter bit CHECK_RSVD = 1'b1
) (
   input  logic [QUAD_W-1:0] first_q,
   input  logic [QUAD_W-1:0] second_q,
   output logic              pass
);
   localparam int ID_HI = QUAD_W - 1;
   localparam int RSVD  = QUAD_W - 9;

   logic inv_ok;
   logic tag_ok;
   logic rsvd_ok;

   assign inv_ok = (second_q == ~first_q);
   assign tag_ok = (first_q[ID_HI -: 2] == 2'b01);

   generate
      if (CHECK_RSVD) begin : g_rsvd
         assign rsvd_ok = ~first_q[RSVD];
      end else begin : g_norsvd
         assign rsvd_ok = 1'b1;
      end
   endgenerate

   assign pass = inv_ok && tag_ok && rsvd_ok;
endmodule

// File: rtl/sid_out.sv
module sid_out
   import sid_pkg::*;
#(
   parameter int QUAD_W   = 32,
   parameter int PORT_CNT = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cmp_fire,
   input  logic                             pass,
   input  logic [QUAD_W-1:0]                held_q,
   output logic                             pkt_ok,
   output logic                             pkt_err,
   output logic [5:0]                       sender_id,
   output logic                             link_active,
   output logic [5:0]                       gap_count,
   output logic [1:0]                       phy_speed,
   output logic [1:0]                       phy_delay,
   output logic                             contender,
   output logic [2:0]                       power_class,
   output logic [PORT_CNT*PORT_FIELD_W-1:0] port_stat,
   output logic                             init_reset,
   output logic                             more_pkts
);
   localparam int PW = PORT_CNT * PORT_FIELD_W;

   // document bit n lives at vector index QUAD_W-1-n
   function automatic int ix(input int n);
      return QUAD_W - 1 - n;
   endfunction

   logic [PW-1:0] port_nx;

   generate
      for (genvar p = 0; p < PORT_CNT; p++) begin : g_port
         assign port_nx[PW-1-PORT_FIELD_W*p -: PORT_FIELD_W] =
            held_q[ix(24 + PORT_FIELD_W*p) -: PORT_FIELD_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_ok      <= 1'b0;
         pkt_err     <= 1'b0;
         sender_id   <= '0;
         link_active <= 1'b0;
         gap_count   <= '0;
         phy_speed   <= '0;
         phy_delay   <= '0;
         contender   <= 1'b0;
         power_class <= '0;
         port_stat   <= '0;
         init_reset  <= 1'b0;
         more_pkts   <= 1'b0;
      end else begin
         pkt_ok  <= cmp_fire && pass;
         pkt_err <= cmp_fire && !pass;
         if (cmp_fire && pass) begin
            sender_id   <= held_q[ix(2) -: 6];
            link_active <= held_q[ix(9)];
            gap_count   <= held_q[ix(10) -: 6];
            phy_speed   <= held_q[ix(16) -: 2];
            phy_delay   <= held_q[ix(18) -: 2];
            contender   <= held_q[ix(20)];
            power_class <= held_q[ix(21) -: 3];
            port_stat   <= port_nx;
            init_reset  <= held_q[ix(QUAD_W-2)];
            more_pkts   <= held_q[ix(QUAD_W-1)];
         end
      end
   end
endmodule

// File: rtl/sid_decode.sv
module sid_decode
   import sid_pkg::*;
#(
   parameter int QUAD_W     = 32,
   parameter int PORT_CNT   = 3,
   parameter bit CHECK_RSVD = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             q_start,
   input  logic                             q_valid,
   input  logic [QUAD_W-1:0]                q_data,
   output logic                             pkt_ok,
   output logic                             pkt_err,
   output logic [5:0]                       sender_id,
   output logic                             link_active,
   output logic [5:0]                       gap_count,
   output logic [1:0]                       phy_speed,
   output logic [1:0]                       phy_delay,
   output logic                             contender,
   output logic [2:0]                       power_class,
   output logic [PORT_CNT*PORT_FIELD_W-1:0] port_stat,
   output logic                             init_reset,
   output logic                             more_pkts
);
   generate
      if (QUAD_W != FIXED_BITS + PORT_FIELD_W * PORT_CNT) begin : g_bad_layout
         $error("sid_decode: QUAD_W does not match PORT_CNT layout");
      end
      if (PORT_CNT < 1) begin : g_bad_ports
         $error("sid_decode: PORT_CNT must be at least 1");
      end
   endgenerate

   logic              cmp_fire;
   logic              pass;
   logic [QUAD_W-1:0] held_q;

   sid_seq #(.QUAD_W(QUAD_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_start  (q_start),
      .q_valid  (q_valid),
      .q_data   (q_data),
      .cmp_fire (cmp_fire),
      .held_q   (held_q)
   );

   sid_check #(.QUAD_W(QUAD_W), .CHECK_RSVD(CHECK_RSVD)) u_check (
      .first_q  (held_q),
      .second_q (q_data),
      .pass     (pass)
   );

   sid_out #(.QUAD_W(QUAD_W), .PORT_CNT(PORT_CNT)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmp_fire    (cmp_fire),
      .pass        (pass),
      .held_q      (held_q),
      .pkt_ok      (pkt_ok),
      .pkt_err     (pkt_err),
      .sender_id   (sender_id),
      .link_active (link_active),
      .gap_count   (gap_count),
      .phy_speed   (phy_speed),
      .phy_delay   (phy_delay),
      .contender   (contender),
      .power_class (power_class),
      .port_stat   (port_stat),
      .init_reset  (init_reset),
      .more_pkts   (more_pkts)
   );
endmodule

// File: rtl/sid_decode_chk.sv
module sid_decode_chk #(
   parameter int QUAD_W   = 32,
   parameter int PORT_CNT = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  q_start,
   input logic                  q_valid,
   input logic                  pkt_ok,
   input logic                  pkt_err,
   input logic [5:0]            sender_id,
   input logic [5:0]            gap_count,
   input logic [2:0]            power_class,
   input logic [PORT_CNT*2-1:0] port_stat,
   input logic                  more_pkts
);
   logic [PORT_CNT*2+15:0] fld;
   assign fld = {sender_id, gap_count, power_class, port_stat, more_pkts};

   assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_ok && pkt_err));

   assert_ok_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ok |=> !pkt_ok);

   assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_err |=> !pkt_err);

   assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_ok |-> $stable(fld));

   assert_pulse_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_ok || pkt_err) |-> $past(q_valid));

   assert_restart_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_ok || pkt_err) |-> !$past(q_start));
endmodule

bind sid_decode sid_decode_chk #(.QUAD_W(QUAD_W), .PORT_CNT(PORT_CNT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .q_start     (q_start),
   .q_valid     (q_valid),
   .pkt_ok      (pkt_ok),
   .pkt_err     (pkt_err),
   .sender_id   (sender_id),
   .gap_count   (gap_count),
   .power_class (power_class),
   .port_stat   (port_stat),
   .more_pkts   (more_pkts)
);

// File: tb/sim_sid_decode.sv
module sim_sid_decode;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        q_start = 1'b0;
   logic        q_valid = 1'b0;
   logic [31:0] q_data = '0;
   logic        pkt_ok, pkt_err;
   logic [5:0]  sender_id, gap_count;
   logic        link_active, contender, init_reset, more_pkts;
   logic [1:0]  phy_speed, phy_delay;
   logic [2:0]  power_class;
   logic [5:0]  port_stat;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] last_good = '0;
   logic        have_good = 1'b0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sid_decode u0 (
      .clk(clk), .rst_n(rst_n), .q_start(q_start), .q_valid(q_valid), .q_data(q_data),
      .pkt_ok(pkt_ok), .pkt_err(pkt_err), .sender_id(sender_id),
      .link_active(link_active), .gap_count(gap_count), .phy_speed(phy_speed),
      .phy_delay(phy_delay), .contender(contender), .power_class(power_class),
      .port_stat(port_stat), .init_reset(init_reset), .more_pkts(more_pkts)
   );

   // bits first..first+len-1, bit 0 = q[31], first bit most significant
   function automatic logic [31:0] fld(input logic [31:0] q, input int first, input int len);
      logic [31:0] r = '0;
      for (int i = 0; i < len; i++) r = (r << 1) | 32'(q[31 - (first + i)]);
      return r;
   endfunction

   function automatic logic [28:0] expect_fields(input logic [31:0] q, input logic any);
      if (!any) return '0;
      return {fld(q,2,6)[5:0], fld(q,9,1)[0], fld(q,10,6)[5:0], fld(q,16,2)[1:0],
              fld(q,18,2)[1:0], fld(q,20,1)[0], fld(q,21,3)[2:0], fld(q,24,6)[5:0],
              fld(q,30,1)[0], fld(q,31,1)[0]};
   endfunction

   function automatic logic [28:0] got_fields();
      return {sender_id, link_active, gap_count, phy_speed, phy_delay, contender,
              power_class, port_stat, init_reset, more_pkts};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one cycle, return at the following falling edge
   task automatic step(input logic v, input logic s, input logic [31:0] d);
      q_valid = v; q_start = s; q_data = d;
      @(negedge clk);
   endtask

   task automatic check_pulses(input string req, input logic ok, input logic er);
      check(req, {62'd0, pkt_ok, pkt_err}, {62'd0, ok, er});
      check(req, {35'd0, got_fields()}, {35'd0, expect_fields(last_good, have_good)});
   endtask

   function automatic logic [31:0] good_quad();
      logic [31:0] q = $urandom;
      q[31:30] = 2'b01;
      q[23] = 1'b0;
      return q;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] a, b;
      void'($urandom(32'h5EED_1D00));
      @(negedge clk);
      step(1'b0, 1'b0, '0);
      check("R1 reset", {35'd0, pkt_ok, pkt_err, got_fields()}, 64'd0);
      rst_n = 1'b1;
      step(1'b0, 1'b0, '0);
      check_pulses("R1 after reset", 1'b0, 1'b0);

      // R2 directed packet
      a = 32'h4350_00FC;
      step(1'b0, 1'b1, 32'hFFFF_FFFF);
      step(1'b1, 1'b0, a);
      step(1'b1, 1'b0, ~a);
      last_good = a; have_good = 1'b1;
      check_pulses("R2 directed", 1'b1, 1'b0);
      step(1'b0, 1'b0, '0);
      check_pulses("R6 single ok", 1'b0, 1'b0);

      // R3 inverse mismatch
      b = good_quad();
      step(1'b1, 1'b1, b);
      step(1'b1, 1'b0, ~b ^ 32'h0000_0100);
      check_pulses("R3 inverse", 1'b0, 1'b1);
      step(1'b0, 1'b0, '0);
      check_pulses("R6 single err", 1'b0, 1'b0);

      // R4 bad identifier
      b = good_quad(); b[31:30] = 2'b11;
      step(1'b1, 1'b1, b);
      step(1'b1, 1'b0, ~b);
      check_pulses("R4 tag", 1'b0, 1'b1);

      // R5 reserved bit
      b = good_quad(); b[23] = 1'b1;
      step(1'b1, 1'b1, b);
      step(1'b1, 1'b0, ~b);
      check_pulses("R5 bit8", 1'b0, 1'b1);

      // R7 strobes with no start
      b = good_quad();
      step(1'b1, 1'b0, b);
      step(1'b1, 1'b0, ~b);
      check_pulses("R7 stray", 1'b0, 1'b0);
      step(1'b1, 1'b0, ~b);
      check_pulses("R7 stray", 1'b0, 1'b0);

      // R8 restart discards held quadlet
      a = good_quad(); b = good_quad();
      step(1'b0, 1'b1, '0);
      step(1'b1, 1'b0, a);
      step(1'b0, 1'b1, ~a);
      check_pulses("R8 restart", 1'b0, 1'b0);
      step(1'b1, 1'b0, b);
      step(1'b1, 1'b0, ~a);
      check_pulses("R8 old held", 1'b0, 1'b1);
      step(1'b1, 1'b1, a);
      step(1'b0, 1'b1, ~a);
      step(1'b1, 1'b0, b);
      step(1'b1, 1'b0, ~b);
      last_good = b;
      check_pulses("R8 new first", 1'b1, 1'b0);

      // R9 start together with data, restart while held
      a = good_quad(); b = good_quad();
      step(1'b1, 1'b1, a);
      step(1'b1, 1'b1, b);
      check_pulses("R9 coincident", 1'b0, 1'b0);
      step(1'b1, 1'b0, ~b);
      last_good = b;
      check_pulses("R9 coincident", 1'b1, 1'b0);

      // random packets with gaps and corruption (R2..R5, R10)
      for (int it = 0; it < 400; it++) begin
         int kind = int'($urandom_range(0, 4));
         int gap;
         a = good_quad();
         if (kind == 2) a[31:30] = 2'($urandom_range(0, 3)) | 2'b10;
         if (kind == 3) a[23] = 1'b1;
         b = ~a;
         if (kind == 1) b[$urandom_range(0, 31)] ^= 1'b1;
         step(1'b0, 1'b1, $urandom);
         gap = int'($urandom_range(0, 2));
         for (int g = 0; g < gap; g++) step(1'b0, 1'b0, $urandom);
         step(1'b1, 1'b0, a);
         gap = int'($urandom_range(0, 2));
         for (int g = 0; g < gap; g++) begin
            step(1'b0, 1'b0, $urandom);
            check_pulses("R10 gap", 1'b0, 1'b0);
         end
         step(1'b1, 1'b0, b);
         if (kind == 0 || kind == 4) begin
            last_good = a;
            check_pulses("R2 random", 1'b1, 1'b0);
         end else begin
            check_pulses(kind == 1 ? "R3 random" : kind == 2 ? "R4 random" : "R5 random",
                         1'b0, 1'b1);
         end
      end

      step(1'b0, 1'b0, '0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule